// File: doc/BRIEF.md
# Multi-Source Configuration Shift Loader

This block fills a configuration word after reset is released. It is 18 bits wide by default, or 19 bits when the extended variant is selected. A two-bit strap code is sampled once, in the first clock cycle after reset, and picks one of three sources.

- **Serial memory.** The block acts as the master of a three-wire serial memory. It generates the memory clock, sends a read command for address zero, and collects the data bits that follow.
- **External clock.** An external master clocks the bits in itself. The pin pair is synchronized, and every detected rising edge shifts in one data bit.
- **Preset table.** The same two pins, together with a third strap pin, form a 3-bit index into an internal eight-entry table of presets. The chosen preset is streamed into the same shift chain.

Whichever source is used, the bits enter the chain in one fixed order. When the last bit has been captured, a one-cycle done pulse is raised. The word then stays frozen until the next reset.

All pin inputs are sampled by the system clock through two-stage synchronizers. Tri-state sensing of the strap pad and pad multiplexing of the shared pins are outside this block. The strap arrives here already decoded.

Top module: `cfg_loader`

## Requirements
- R1: While rst_n is low, cfgWord is all zeros and configDone, memClkOut and memDiOut are 0.
- R2: modeStrap is sampled only in the first clock cycle after reset release: 2'b00 selects the preset table, 2'b01 selects the external clock, and 2'b10 or 2'b11 selects the serial memory. Later changes to it have no effect until the next reset.
- R3: Bits enter at bit 0 and move toward the MSB, so the first bit received ends at the top. The 18-bit layout is M[5:0] at [17:12], TEST at [11], CS at [10], CM at [9], R[1:0] at [8:7] and N[6:0] at [6:0]. The first bit received is M5 and the last is N0.
- R4: In external-clock mode, each rising edge of mclkIn (seen after synchronization) shifts in the current mdoutIn level. A level that is already high at reset release is not an edge. Each clock phase must last at least 3 system clock cycles.
- R5: After the last bit is captured, further mclkIn edges and mdoutIn changes leave cfgWord unchanged until reset.
- R6: In preset mode, the index is {romMsbIn, mclkIn, mdoutIn}, with romMsbIn as the MSB. The indexed preset is loaded through the same chain.
- R7: The presets are given as (CS, CM, R, M, N, TEST):
  - 0 = 1,1,01,0,0,0
  - 1 = 1,1,10,5,2,0
  - 2 = 1,1,01,2,5,0
  - 3 = 1,0,01,0,0,0
  - 4 = 0,0,01,0,0,0
  - 5 = 0,0,10,5,2,0
  - 6 = 0,0,01,2,5,0
  - 7 = TEST 1, with every other field 0
- R8: In serial-memory mode, memClkOut is low for HALF cycles and then high for HALF cycles. During the first 9 memory clocks, memDiOut carries 1,1,0 followed by six zeros, stable at each rising edge. It is 0 otherwise.
- R9: In serial-memory mode, mdoutIn is sampled at the end of the high phase of memory clocks 10 through 9+CFG_BITS, first bit first. After that no further memory clock is produced.
- R10: configDone is high for exactly one cycle per reset. That cycle is the first one in which the complete word is visible on cfgWord.
- R11: The extended variant has 19 bits. A deskew-disable bit sits at position 9, between CM and R1, and the M, TEST, CS and CM fields each move up by one position. This bit is 0 in every preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeStrap | input | 2 | Decoded source strap |
| mclkIn | input | 1 | External serial clock, or preset index bit 1 |
| mdoutIn | input | 1 | Serial data in, or preset index bit 0 |
| romMsbIn | input | 1 | Preset index bit 2 |
| memClkOut | output | 1 | Generated serial memory clock |
| memDiOut | output | 1 | Command bits to the serial memory |
| cfgWord | output | CFG_BITS | Loaded configuration word |
| configDone | output | 1 | One-cycle pulse when loading completes |

## Verification
The checker watches, on every cycle, the properties that need no knowledge of the stream:
- the reset state;
- that there is only one done pulse per reset;
- that the done pulse comes after exactly CFG_BITS shifts and never more;
- that the word stays frozen after completion;
- that the memory pins are quiet after completion.

The remaining behaviours can only be shown by the bench's scenarios:
- the bit order and field positions;
- the preset contents;
- the decoding of each strap code;
- the command sequence and clock period on the memory pins;
- rejection of a high clock level present at reset release.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int POS_W = 5;

  typedef enum logic [1:0] {
    SRC_ROM = 2'd0,
    SRC_EXT = 2'd1,
    SRC_MEM = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    ST_STRAP = 2'd0,
    ST_LOAD  = 2'd1,
    ST_HOLD  = 2'd2
  } phase_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             shiftEn;
    src_e             src;
    logic [POS_W-1:0] romPos;
  } strobe_t;

  function automatic src_e decodeStrap(input logic [1:0] s);
    if (s[1])      return SRC_MEM;
    else if (s[0]) return SRC_EXT;
    else           return SRC_ROM;
  endfunction

  // Preset in the 19-bit layout: {M, TEST, CS, CM, DDSK, R, N}
  function automatic logic [18:0] presetWide(input logic [2:0] code);
    logic [5:0] m;
    logic [6:0] n;
    logic [1:0] r;
    logic       cs, cm, tst;
    m = '0; n = '0; r = 2'b01; cs = 1'b0; cm = 1'b0; tst = 1'b0;
    case (code)
      3'd0: begin cs = 1'b1; cm = 1'b1; end
      3'd1: begin cs = 1'b1; cm = 1'b1; r = 2'b10; m = 6'd5; n = 7'd2; end
      3'd2: begin cs = 1'b1; cm = 1'b1; m = 6'd2; n = 7'd5; end
      3'd3: begin cs = 1'b1; end
      3'd4: begin end
      3'd5: begin r = 2'b10; m = 6'd5; n = 7'd2; end
      3'd6: begin m = 6'd2; n = 7'd5; end
      default: begin r = 2'b00; tst = 1'b1; end
    endcase
    return {m, tst, cs, cm, 1'b0, r, n};
  endfunction

endpackage

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int CFG_BITS = 18,
  parameter bit EXTENDED = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mclkIn,
  input  logic                mdoutIn,
  input  logic                romMsbIn,
  input  strobe_t             strobe,
  output logic                mclkRise,
  output logic [CFG_BITS-1:0] cfgWord
);

  // pin order {romMsb, mclk, mdout}; the clock stage resets high so a
  // level already high at release is never taken for an edge
  localparam logic [2:0] SYNC_INIT = 3'b010;

  logic [2:0] pinsRaw;
  logic [2:0] stage1;
  logic [2:0] stage2;
  logic       mclkPrev;

  assign pinsRaw = {romMsbIn, mclkIn, mdoutIn};

  for (genvar g = 0; g < 3; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[g] <= SYNC_INIT[g];
        stage2[g] <= SYNC_INIT[g];
      end else begin
        stage1[g] <= pinsRaw[g];
        stage2[g] <= stage1[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mclkPrev <= 1'b1;
    else        mclkPrev <= stage2[1];
  end

  assign mclkRise = stage2[1] & ~mclkPrev;

  logic [18:0]         presetFull;
  logic [CFG_BITS-1:0] romWord;

  assign presetFull = presetWide(stage2);

  if (EXTENDED) begin : g_wide
    assign romWord = presetFull;
  end else begin : g_narrow
    assign romWord = {presetFull[18:10], presetFull[8:0]};
  end

  logic serialBit;
  always_comb begin
    if (strobe.src == SRC_ROM) serialBit = romWord[strobe.romPos];
    else                       serialBit = stage2[0];
  end

  logic [CFG_BITS-1:0] shiftReg;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[CFG_BITS-2:0], serialBit};
  end

  assign cfgWord = shiftReg;

endmodule

// File: rtl/cfg_loader_ctl.sv
module cfg_loader_ctl
  import cfg_loader_pkg::*;
#(
  parameter int CFG_BITS = 18,
  parameter int HALF     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] modeStrap,
  input  logic       mclkRise,
  output strobe_t    strobe,
  output logic       memClkOut,
  output logic       memDiOut,
  output logic       configDone
);

  localparam int         CMD_LEN = 9;
  localparam logic [8:0] CMD     = 9'b110_000000;
  localparam int         TOTAL   = CMD_LEN + CFG_BITS;
  localparam int         PH_W    = $clog2(2 * HALF);
  localparam int         CYC_W   = $clog2(TOTAL + 1);
  localparam int         CNT_W   = $clog2(CFG_BITS + 1);

  phase_e             state;
  src_e               src;
  logic [CNT_W-1:0]   bitCnt;
  logic [POS_W-1:0]   romPos;
  logic [PH_W-1:0]    phaseCnt;
  logic [CYC_W-1:0]   cycIdx;
  logic [CMD_LEN-1:0] cmdShift;
  logic [1:0]         settleCnt;
  logic               doneQ;

  logic inMem, phaseEnd, settled, shiftNow, shiftEn, lastBit;

  always_comb begin
    inMem    = (state == ST_LOAD) && (src == SRC_MEM);
    phaseEnd = phaseCnt == PH_W'(2 * HALF - 1);
    settled  = settleCnt == 2'd2;
    lastBit  = bitCnt == CNT_W'(CFG_BITS - 1);
    case (src)
      SRC_ROM: shiftNow = settled;
      SRC_EXT: shiftNow = mclkRise;
      default: shiftNow = phaseEnd && (cycIdx >= CYC_W'(CMD_LEN));
    endcase
    shiftEn = (state == ST_LOAD) && shiftNow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_STRAP;
      src       <= SRC_ROM;
      bitCnt    <= '0;
      romPos    <= POS_W'(CFG_BITS - 1);
      phaseCnt  <= '0;
      cycIdx    <= '0;
      cmdShift  <= CMD;
      settleCnt <= '0;
      doneQ     <= 1'b0;
    end else begin
      doneQ <= shiftEn && lastBit;
      case (state)
        ST_STRAP: begin
          src   <= decodeStrap(modeStrap);
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (!settled) settleCnt <= settleCnt + 2'd1;
          if (inMem) begin
            phaseCnt <= phaseEnd ? '0 : phaseCnt + PH_W'(1);
            if (phaseEnd) begin
              cycIdx   <= cycIdx + CYC_W'(1);
              cmdShift <= {cmdShift[CMD_LEN-2:0], 1'b0};
            end
          end
          if (shiftEn) begin
            bitCnt <= bitCnt + CNT_W'(1);
            romPos <= romPos - POS_W'(1);
            if (lastBit) state <= ST_HOLD;
          end
        end
        default: state <= ST_HOLD;
      endcase
    end
  end

  assign strobe     = '{shiftEn: shiftEn, src: src, romPos: romPos};
  assign memClkOut  = inMem && (phaseCnt >= PH_W'(HALF));
  assign memDiOut   = inMem && cmdShift[CMD_LEN-1];
  assign configDone = doneQ;

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter bit EXTENDED = 1'b0,
  parameter int HALF     = 8,
  localparam int CFG_BITS = EXTENDED ? 19 : 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          modeStrap,
  input  logic                mclkIn,
  input  logic                mdoutIn,
  input  logic                romMsbIn,
  output logic                memClkOut,
  output logic                memDiOut,
  output logic [CFG_BITS-1:0] cfgWord,
  output logic                configDone
);

  strobe_t strobe;
  logic    mclkRise;
  logic    shiftPulse;

  cfg_loader_ctl #(.CFG_BITS(CFG_BITS), .HALF(HALF)) u_ctl (
    .clk(clk), .rst_n(rst_n), .modeStrap(modeStrap), .mclkRise(mclkRise),
    .strobe(strobe), .memClkOut(memClkOut), .memDiOut(memDiOut),
    .configDone(configDone)
  );

  cfg_loader_dp #(.CFG_BITS(CFG_BITS), .EXTENDED(EXTENDED)) u_dp (
    .clk(clk), .rst_n(rst_n), .mclkIn(mclkIn), .mdoutIn(mdoutIn),
    .romMsbIn(romMsbIn), .strobe(strobe), .mclkRise(mclkRise),
    .cfgWord(cfgWord)
  );

  assign shiftPulse = strobe.shiftEn;

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int CFG_BITS = 18
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CFG_BITS-1:0] cfgWord,
  input logic                configDone,
  input logic                memClkOut,
  input logic                memDiOut,
  input logic                shiftPulse
);

  localparam int SC_W = $clog2(CFG_BITS + 2);

  logic [SC_W-1:0] shiftCnt;
  logic            seenDone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftCnt <= '0;
      seenDone <= 1'b0;
    end else begin
      if (shiftPulse) shiftCnt <= shiftCnt + SC_W'(1);
      if (configDone) seenDone <= 1'b1;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (cfgWord == '0 && !configDone && !memClkOut && !memDiOut));

  a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    configDone |-> !seenDone);

  a_r10_done_after_all_bits: assert property (@(posedge clk) disable iff (!rst_n)
    configDone |-> shiftCnt == SC_W'(CFG_BITS));

  a_r5_no_extra_shift: assert property (@(posedge clk) disable iff (!rst_n)
    shiftCnt <= SC_W'(CFG_BITS));

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    seenDone |-> $stable(cfgWord));

  a_r9_mem_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
    (seenDone || configDone) |-> (!memClkOut && !memDiOut));

endmodule

bind cfg_loader cfg_loader_chk #(.CFG_BITS(CFG_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfgWord(cfgWord), .configDone(configDone),
  .memClkOut(memClkOut), .memDiOut(memDiOut), .shiftPulse(shiftPulse)
);

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] modeStrap = 2'b00;
  logic       mclkDrv = 1'b0;
  logic       mdoutDrv = 1'b0;
  logic       romMsb = 1'b0;
  logic       useMem = 1'b0;
  logic       memOut;
  logic       mdoutPin;

  logic        memClk18, memDi18, done18;
  logic        memClk19, memDi19, done19;
  logic [17:0] word18;
  logic [18:0] word19;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign mdoutPin = useMem ? memOut : mdoutDrv;

  cfg_loader #(.EXTENDED(1'b0), .HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .modeStrap(modeStrap), .mclkIn(mclkDrv),
    .mdoutIn(mdoutPin), .romMsbIn(romMsb), .memClkOut(memClk18),
    .memDiOut(memDi18), .cfgWord(word18), .configDone(done18)
  );

  cfg_loader #(.EXTENDED(1'b1), .HALF(HALF)) dut19 (
    .clk(clk), .rst_n(rst_n), .modeStrap(modeStrap), .mclkIn(mclkDrv),
    .mdoutIn(mdoutPin), .romMsbIn(romMsb), .memClkOut(memClk19),
    .memDiOut(memDi19), .cfgWord(word19), .configDone(done19)
  );

  // serial memory model, clocked by the longer (19-bit) reader
  logic [18:0] memStream = '0;
  int          edges19 = 0;
  int          edges18 = 0;
  logic [8:0]  cmdCap = '0;
  time         lastRise = 0;
  time         periodSeen = 0;

  always @(posedge memClk19 or negedge rst_n) begin
    if (!rst_n) begin
      edges19 <= 0; memOut <= 1'b0; cmdCap <= '0;
    end else begin
      edges19 <= edges19 + 1;
      if (edges19 < 9) cmdCap <= {cmdCap[7:0], memDi19};
      if (edges19 + 1 >= 10 && edges19 + 1 <= 28) memOut <= memStream[18 - (edges19 + 1 - 10)];
      if (edges19 == 1) periodSeen <= $time - lastRise;
      lastRise <= $time;
    end
  end

  always @(posedge memClk18 or negedge rst_n) begin
    if (!rst_n) edges18 <= 0;
    else        edges18 <= edges18 + 1;
  end

  // done monitors
  int          doneCnt18 = 0, doneCnt19 = 0;
  logic [17:0] doneWord18 = '0;
  logic [18:0] doneWord19 = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      doneCnt18 <= 0; doneCnt19 <= 0;
    end else begin
      if (done18) begin doneCnt18 <= doneCnt18 + 1; doneWord18 <= word18; end
      if (done19) begin doneCnt19 <= doneCnt19 + 1; doneWord19 <= word19; end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] pack19(input logic [5:0] m, input logic t, input logic cs,
      input logic cm, input logic dd, input logic [1:0] r, input logic [6:0] n);
    return {m, t, cs, cm, dd, r, n};
  endfunction

  function automatic logic [17:0] to18(input logic [18:0] w);
    return {w[18:10], w[8:0]};
  endfunction

  function automatic logic [18:0] expPreset(input int code);
    case (code)
      0: return pack19(6'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 7'd0);
      1: return pack19(6'd5, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 7'd2);
      2: return pack19(6'd2, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 7'd5);
      3: return pack19(6'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01, 7'd0);
      4: return pack19(6'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 7'd0);
      5: return pack19(6'd5, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 7'd2);
      6: return pack19(6'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01, 7'd5);
      default: return pack19(6'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 7'd0);
    endcase
  endfunction

  task automatic applyReset(input logic [1:0] strap, input logic msb, input logic mclkL,
                            input logic mdoutL, input logic mem);
    @(negedge clk);
    rst_n = 1'b0;
    modeStrap = strap; romMsb = msb; mclkDrv = mclkL; mdoutDrv = mdoutL; useMem = mem;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic extBit(input logic b);
    mdoutDrv = b;
    mclkDrv = 1'b0;
    repeat (4) @(negedge clk);
    mclkDrv = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic extStream(input logic [18:0] sv);
    for (int i = 18; i >= 0; i--) extBit(sv[i]);
    repeat (6) @(negedge clk);
  endtask

  task automatic checkDone(input string req, input logic [17:0] e18, input logic [18:0] e19);
    check({req, " done18 count"}, doneCnt18, 1);
    check({req, " done19 count"}, doneCnt19, 1);
    check({req, " done18 word"}, doneWord18, e18);
    check({req, " done19 word"}, doneWord19, e19);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    logic [18:0] sv;
    void'($urandom(32'd1729));

    // R1: reset state
    repeat (2) @(negedge clk);
    check("R1 word18", word18, 0);
    check("R1 word19", word19, 0);
    check("R1 done/mem pins", {done18, memClk18, memDi18, done19, memClk19, memDi19}, 0);

    // R6 R7 R11: every preset
    for (int code = 0; code < 8; code++) begin
      applyReset(2'b00, code[2], code[1], code[0], 1'b0);
      repeat (40) @(negedge clk);
      check($sformatf("R7 preset %0d narrow", code), word18, to18(expPreset(code)));
      check($sformatf("R11 preset %0d wide", code), word19, expPreset(code));
      check("R6 no memory clock in preset mode", edges19, 0);
      checkDone("R10 preset", to18(expPreset(code)), expPreset(code));
    end

    // R3 R4: directed field layout, clock already high at release
    sv = {to18(pack19(6'b101001, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 7'b0110011)), 1'b1};
    applyReset(2'b01, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (6) @(negedge clk);
    extStream(sv);
    check("R3 field layout", word18, 18'b101001_0_1_0_10_0110011);
    check("R4 high level at release not an edge", word19, sv);
    checkDone("R10 external", sv[18:1], sv);

    // R5: extra edges ignored
    for (int i = 0; i < 6; i++) extBit(~sv[i]);
    repeat (4) @(negedge clk);
    check("R5 narrow frozen", word18, sv[18:1]);
    check("R5 wide frozen", word19, sv);
    check("R5 no second done", doneCnt18 + doneCnt19, 2);

    // R11: extra bit placement
    sv = pack19(6'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 7'd0);
    applyReset(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    extStream(sv);
    check("R11 deskew bit at 9", word19, 19'h00200);

    // R2: strap changed after sampling has no effect
    sv = 19'h5A3C6;
    applyReset(2'b01, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    modeStrap = 2'b10;
    extStream(sv);
    check("R2 late strap ignored", word18, sv[18:1]);
    check("R2 no memory clock", edges19, 0);

    // R4: random external streams
    for (int i = 0; i < 6; i++) begin
      sv = 19'($urandom);
      applyReset(2'b01, 1'($urandom), 1'($urandom), 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      extStream(sv);
      check("R4 random narrow", word18, sv[18:1]);
      check("R4 random wide", word19, sv);
      checkDone("R10 random", sv[18:1], sv);
    end

    // R8 R9: serial memory, both strap codes
    for (int i = 0; i < 4; i++) begin
      sv = 19'($urandom);
      memStream = sv;
      applyReset((i % 2 == 0) ? 2'b10 : 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
      repeat (28 * 2 * HALF + 20) @(negedge clk);
      check("R9 memory narrow", word18, sv[18:1]);
      check("R9 memory wide", word19, sv);
      check("R8 command bits", cmdCap, 9'b110000000);
      check("R8 clock period ns", 32'(periodSeen), 32'(2 * HALF * 20));
      check("R9 narrow clock count", edges18, 27);
      check("R9 wide clock count", edges19, 28);
      check("R8 pins idle", {memClk18, memDi18, memClk19, memDi19}, 0);
      checkDone("R10 memory", sv[18:1], sv);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule